// File: doc/BRIEF.md
# Scan Chain Timing Fault Classifier

This block is on-chip test logic for one scan chain of `CHAIN_LEN` cells. When started, it drives the chain's serial input and shift enable through two load/unload passes. It never issues a capture clock. It listens on the chain's serial output and counts the ones that come back. From those counts it decides three things:

- whether the chain is sound;
- if it is not, whether the damage comes from cells that latch too late (setup-time faults) or too early (hold-time faults);
- how many such cells there are.

Each pass has three phases:

1. Flush the chain with one constant value.
2. Load a thermometer-like word, zeros toward the output end and ones toward the input end. The second pass uses the inverted word.
3. Shift the word straight back out.

A late-latching cell delays the single edge of the word by one shift. An early-latching cell advances it by one shift. The number of ones that come back therefore moves by one for every faulty cell, and it moves in opposite directions in the two passes. The sign of the shift gives the fault kind and its size gives the fault count. If the two passes do not move by equal and opposite amounts, the result is flagged as inconsistent and no type or count is reported.

Top module: `scan_fault_checker`

## Requirements
- R1: After reset, busy, done, scan_en, chain_pass, fault_hold, inconsistent and fault_cnt are all 0.
- R2: A start pulse while idle begins a run. In the run, scan_en is high for exactly 6*CHAIN_LEN consecutive cycles. Each of the two passes in turn takes CHAIN_LEN flush shifts, then CHAIN_LEN load shifts, then CHAIN_LEN unload shifts. The scan_si stream of the run has exactly two value changes and holds exactly 3*CHAIN_LEN ones.
- R3: With a sound chain, the run ends with chain_pass=1, fault_cnt=0, fault_hold=0 and inconsistent=0.
- R4: With f late-latching (setup-time) cells, the first pass returns f fewer ones and the second pass f more ones than a sound chain. The result is then chain_pass=0, fault_hold=0 (0 encodes setup-time), fault_cnt=f and inconsistent=0.
- R5: With f early-latching (hold-time) cells, the deviations are reversed. The result is then chain_pass=0, fault_hold=1 (1 encodes hold-time), fault_cnt=f and inconsistent=0.
- R6: When the two passes' deviations are not equal and opposite, the result is inconsistent=1, chain_pass=0, fault_hold=0 and fault_cnt=0. A stuck-at-0 or stuck-at-1 serial output is one such case.
- R7: The expected counts of returned ones follow from the chain length, including odd lengths. In the first pass the load word holds floor(CHAIN_LEN/2) zeros, shifted first, followed by ceil(CHAIN_LEN/2) ones. The second pass uses the bitwise inverse. During unload, scan_si repeats the last loaded bit.
- R8: done is a single-cycle pulse, raised the cycle after the last unload shift. The results change only with done and hold until the next run. A start pulse during a run is ignored.
- R9: A fault count up to floor(CHAIN_LEN/2) in either direction is reported exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| scan_so | input | 1 | Serial output of the chain under check |
| scan_en | output | 1 | Shift enable to the chain |
| scan_si | output | 1 | Serial input to the chain |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle result strobe |
| chain_pass | output | 1 | Both passes returned the expected counts |
| fault_hold | output | 1 | 1 = hold-time faults, 0 = setup-time faults |
| fault_cnt | output | $clog2(CHAIN_LEN+1) | Number of faulty cells |
| inconsistent | output | 1 | The two passes disagree |

## Verification
The bench builds the block with CHAIN_LEN=13. This odd length makes the upstream half one cell longer than the downstream half, so the length adjustment of R7 is exercised. It also makes a count of 6 the largest exactly reportable fault count, and a bench-side chain model can reach that limit in both directions. The chain model delays or advances the returned stream by the number of injected faulty cells. It can also force the output stuck at either level to provoke the inconsistent outcome.

// File: rtl/scan_fault_checker.sv
module scan_fault_checker #(
  parameter int CHAIN_LEN = 16,
  localparam int CNT_W = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scan_so,
  output logic             scan_en,
  output logic             scan_si,
  output logic             busy,
  output logic             done,
  output logic             chain_pass,
  output logic             fault_hold,
  output logic [CNT_W-1:0] fault_cnt,
  output logic             inconsistent
);
  localparam int IDX_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
  localparam int DEV_W = CNT_W + 2;
  localparam int UP_N  = (CHAIN_LEN + 1) / 2;
  localparam int DN_N  = CHAIN_LEN / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);
  localparam logic [IDX_W-1:0] EDGE_IDX = IDX_W'(DN_N);
  localparam logic signed [DEV_W-1:0] UP_S = DEV_W'(UP_N);
  localparam logic signed [DEV_W-1:0] DN_S = DEV_W'(DN_N);

  typedef enum logic [2:0] {S_IDLE, S_FLUSH, S_LOAD, S_UNLD, S_EVAL} phase_t;

  phase_t           phase;
  logic             inv_pass;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] ones_a, ones_b;

  wire idx_last = (idx == LAST_IDX);

  assign busy    = (phase != S_IDLE);
  assign scan_en = (phase == S_FLUSH) || (phase == S_LOAD) || (phase == S_UNLD);

  always_comb begin
    case (phase)
      S_FLUSH: scan_si = inv_pass;
      S_LOAD:  scan_si = inv_pass ^ (idx >= EDGE_IDX);
      S_UNLD:  scan_si = ~inv_pass;
      default: scan_si = 1'b0;
    endcase
  end

  logic signed [DEV_W-1:0] dev_a, dev_b;
  assign dev_a = $signed({2'b00, ones_a}) - UP_S;
  assign dev_b = $signed({2'b00, ones_b}) - DN_S;

  wire balanced = ((dev_a + dev_b) == '0);
  wire a_high   = (dev_a > 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= S_IDLE;
      inv_pass     <= 1'b0;
      idx          <= '0;
      ones_a       <= '0;
      ones_b       <= '0;
      done         <= 1'b0;
      chain_pass   <= 1'b0;
      fault_hold   <= 1'b0;
      fault_cnt    <= '0;
      inconsistent <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        S_IDLE: if (start) begin
          phase    <= S_FLUSH;
          inv_pass <= 1'b0;
          idx      <= '0;
          ones_a   <= '0;
          ones_b   <= '0;
        end
        S_FLUSH: begin
          idx <= idx_last ? '0 : idx + IDX_W'(1);
          if (idx_last) phase <= S_LOAD;
        end
        S_LOAD: begin
          idx <= idx_last ? '0 : idx + IDX_W'(1);
          if (idx_last) phase <= S_UNLD;
        end
        S_UNLD: begin
          idx <= idx_last ? '0 : idx + IDX_W'(1);
          if (scan_so) begin
            if (inv_pass) ones_b <= ones_b + CNT_W'(1);
            else          ones_a <= ones_a + CNT_W'(1);
          end
          if (idx_last) begin
            if (inv_pass) phase <= S_EVAL;
            else begin
              phase    <= S_FLUSH;
              inv_pass <= 1'b1;
            end
          end
        end
        S_EVAL: begin
          phase        <= S_IDLE;
          done         <= 1'b1;
          inconsistent <= !balanced;
          chain_pass   <= balanced && (dev_a == '0);
          fault_hold   <= balanced && a_high;
          if (!balanced)   fault_cnt <= '0;
          else if (a_high) fault_cnt <= CNT_W'(dev_a);
          else             fault_cnt <= CNT_W'(-dev_a);
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_fault_checker_sva.sv
module scan_fault_checker_sva #(
  parameter int CHAIN_LEN = 16,
  localparam int CNT_W = $clog2(CHAIN_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             scan_en,
  input logic             busy,
  input logic             done,
  input logic             chain_pass,
  input logic             fault_hold,
  input logic [CNT_W-1:0] fault_cnt,
  input logic             inconsistent
);
  a_r1_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scan_en);

  a_r2_shift_starts_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> $past(start));

  a_r8_done_follows_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |=> done);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_results_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(chain_pass) && $stable(fault_hold) &&
               $stable(fault_cnt) && $stable(inconsistent)));

  a_r3_pass_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    chain_pass |-> (fault_cnt == '0 && !fault_hold && !inconsistent));

  a_r6_inconsistent_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    inconsistent |-> (!chain_pass && !fault_hold && fault_cnt == '0));

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_cnt <= CNT_W'(CHAIN_LEN / 2)));
endmodule

bind scan_fault_checker scan_fault_checker_sva #(.CHAIN_LEN(CHAIN_LEN)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en), .busy(busy),
  .done(done), .chain_pass(chain_pass), .fault_hold(fault_hold),
  .fault_cnt(fault_cnt), .inconsistent(inconsistent)
);

// File: tb/scan_fault_checker_test.sv
module scan_fault_checker_test;
  localparam int PERIOD = 10;
  localparam int CL = 13;
  localparam int CW = $clog2(CL + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic scan_so, scan_en, scan_si, busy, done;
  logic chain_pass, fault_hold, inconsistent;
  logic [CW-1:0] fault_cnt;

  always #(PERIOD/2) clk = ~clk;

  scan_fault_checker #(.CHAIN_LEN(CL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_so(scan_so),
    .scan_en(scan_en), .scan_si(scan_si), .busy(busy), .done(done),
    .chain_pass(chain_pass), .fault_hold(fault_hold),
    .fault_cnt(fault_cnt), .inconsistent(inconsistent));

  // chain model: fault cells shift the returned stream by one shift each
  bit log_mem [0:4095];
  int k = 0, sh_total = 0, on_total = 0, tr_total = 0;
  bit last_si = 0;
  int n_st = 0, n_ht = 0, stuck = 0;
  int delay;
  assign delay = CL + n_st - n_ht;
  assign scan_so = (stuck == 1) ? 1'b0 : (stuck == 2) ? 1'b1 :
                   (k >= delay) ? log_mem[(k - delay) % 4096] : 1'b0;

  always @(posedge clk) if (scan_en) begin
    log_mem[k % 4096] <= scan_si;
    k        <= k + 1;
    sh_total <= sh_total + 1;
    on_total <= on_total + int'(scan_si);
    if (scan_si != last_si) tr_total <= tr_total + 1;
    last_si  <= scan_si;
  end

  typedef struct {
    bit    pass, hold, inc;
    int    cnt, sh0, on0, tr0;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;

  task automatic check(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // monitor: pops expectations as results appear
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check("R8 done width", int'(done), 0);
      if (done) begin
        if (q.size() == 0) check("R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " pass"}, int'(chain_pass), int'(e.pass));
          check({e.tag, " hold"}, int'(fault_hold), int'(e.hold));
          check({e.tag, " cnt"}, int'(fault_cnt), e.cnt);
          check({e.tag, " inconsistent"}, int'(inconsistent), int'(e.inc));
          check("R2 shift count", sh_total - e.sh0, 6 * CL);
          check("R2 R7 si ones", on_total - e.on0, 3 * CL);
          check("R2 si transitions", tr_total - e.tr0, 2);
        end
      end
      prev_done = done;
    end
  end

  task automatic run(string tag, int st, int ht, int sk,
                     bit e_pass, bit e_hold, bit e_inc, int e_cnt, bit poke);
    exp_t e;
    @(negedge clk);
    n_st = st; n_ht = ht; stuck = sk;
    e.pass = e_pass; e.hold = e_hold; e.inc = e_inc; e.cnt = e_cnt;
    e.sh0 = sh_total; e.on0 = on_total; e.tr0 = tr_total; e.tag = tag;
    q.push_back(e);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 scan_en", int'(scan_en), 0);
    check("R1 done", int'(done), 0);
    check("R1 results", int'({chain_pass, fault_hold, inconsistent}), 0);
    check("R1 fault_cnt", int'(fault_cnt), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run("R3 R7 good chain",     0, 0, 0, 1, 0, 0, 0, 0);
    run("R4 setup f=1",         1, 0, 0, 0, 0, 0, 1, 0);
    run("R4 setup f=3",         3, 0, 0, 0, 0, 0, 3, 0);
    run("R4 R9 setup f=6",      6, 0, 0, 0, 0, 0, 6, 0);
    run("R5 hold f=1",          0, 1, 0, 0, 1, 0, 1, 0);
    run("R5 hold f=2",          0, 2, 0, 0, 1, 0, 2, 0);
    run("R5 R9 hold f=6",       0, 6, 0, 0, 1, 0, 6, 0);
    run("R6 stuck low",         0, 0, 1, 0, 0, 1, 0, 0);
    run("R6 stuck high",        0, 0, 2, 0, 0, 1, 0, 0);
    run("R8 start while busy",  0, 3, 0, 0, 1, 0, 3, 1);
    run("R3 good after faults", 0, 0, 0, 1, 0, 0, 0, 0);
    check("R8 results held", int'(chain_pass), 1);
    check("R8 idle after run", int'(busy), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule